// File: doc/BRIEF.md
# Indirect Test-Pattern Buffer Load Port

This block holds a write data buffer for memory test patterns and lets a register bus fill it one 64-bit chunk at a time. Each load takes four register writes. Software first writes the low 32 bits of the data word, then the high 32 bits. Next it writes a selection register that picks the chunk and the access mode. Last it writes a command register that names the cacheline. That last write is the only thing that stores data in the buffer, and only when it carries the store opcode and the selection register holds a valid load setting.

The buffer holds 64 cachelines of 8 chunks, each 64 bits wide. A synchronous read port returns one entry a cycle after it is requested, so the stored patterns can be checked. Staged data survives a commit, so one data word can be placed into several chunks without writing it again.

Both interfaces use valid/ready handshakes. The register port always asserts `cfg_ready` and accepts one register write in every cycle where `cfg_valid` is high. The read request port always asserts `rd_ready`. The response has no back-pressure: `rsp_valid` is high for exactly one cycle, and the consumer must take the data in that cycle.

Top module: `tbuf_load_port`

## Requirements
- R1: A write to register offset 0 stages data bits 31:0, and a write to offset 1 stages data bits 63:32. A commit stores {high, low}. Staged data stays until it is written again, so several commits can reuse it.
- R2: A write to offset 3 (command) with bits 27:24 equal to 4'b1000 stores the staged word at the cacheline given by bits 11:0 and at the chunk given by bits 3:0 of the selection register at offset 2.
- R3: A commit happens only when, in the selection register, bits 17:16 equal 1, bits 9:5 equal 0 and bit 11 is 0. Any other setting leaves the buffer unchanged.
- R4: A command write whose bits 27:24 differ from 4'b1000 changes no entry, even if another 4-bit command field (bits 23:20 or 31:28) holds 4'b1000.
- R5: A command whose cacheline field is 64 or more is ignored, and so is a chunk select of 8 or more. Neither one wraps onto a lower entry.
- R6: Writing zero to the selection register returns the port to idle, and later command writes store nothing until a load setting is written again.
- R7: A read request accepted in cycle N gives `rsp_valid` high with the entry's data in cycle N+1. Without a request, `rsp_valid` stays low. Back-to-back requests give back-to-back responses.
- R8: When a read and a commit to the same entry fall in the same cycle, the read returns the content from before the commit.
- R9: Reset clears the staged data and the selection register. After reset, `rsp_valid` is low and a command write alone stores nothing. Buffer contents are not cleared.
- R10: `cfg_ready` and `rd_ready` are high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register write request |
| cfg_ready | output | 1 | Register write accepted (always 1) |
| cfg_addr | input | 2 | Register offset: 0 data low, 1 data high, 2 selection, 3 command |
| cfg_wdata | input | 32 | Register write data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read request accepted (always 1) |
| rd_line | input | 6 | Cacheline to read |
| rd_chunk | input | 3 | Chunk to read |
| rsp_valid | output | 1 | Read response valid, one-cycle pulse |
| rsp_data | output | 64 | Read response data |

## Verification
A commit and a read of the same entry can fall in the same cycle. The bench provokes this by driving the command write and the read request on the same clock edge, with the entry already holding a known older word. The scoreboard expects the older word for that read, and then expects the new word from a read issued one cycle later. The gating rules are judged the same way: after each blocked command write, a read must return the untouched earlier content.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    OFS_DLO = 2'd0,
    OFS_DHI = 2'd1,
    OFS_SEL = 2'd2,
    OFS_CMD = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic       rsv31;
    logic [1:0] shadow;
    logic       stage_en;
    logic [3:0] mpb_ofs;
    logic [5:0] mp_map;
    logic [1:0] mode;
    logic [3:0] dword;
    logic       replicate;
    logic       compare;
    logic [4:0] array_sel;
    logic       rsv4;
    logic [3:0] chunk_sel;
  } sel_reg_t;

  typedef struct packed {
    logic [3:0]  op_c;
    logic [3:0]  op_b;
    logic [3:0]  op_a;
    logic        pol1;
    logic        pol0;
    logic        seq_en;
    logic        addr_en;
    logic [3:0]  rsv;
    logic [11:0] line_addr;
  } cmd_reg_t;

  localparam logic [3:0] OP_STORE  = 4'b1000;
  localparam logic [1:0] MODE_LOAD = 2'd1;
endpackage

// File: rtl/tbuf_stage_regs.sv
module tbuf_stage_regs
  import tbuf_pkg::*;
#(
  parameter int DATA_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [DATA_W-1:0] staged,
  output sel_reg_t          sel
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      sel  <= '0;
    end else if (wr_en) begin
      unique case (reg_ofs_e'(wr_addr))
        OFS_DLO: lo_q <= wr_data[HALF_W-1:0];
        OFS_DHI: hi_q <= wr_data[HALF_W-1:0];
        OFS_SEL: sel  <= sel_reg_t'(wr_data);
        default: ;
      endcase
    end
  end

  assign staged = {hi_q, lo_q};

  p_data_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_DLO) |=> (staged[HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

  p_sel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_SEL && wr_data == '0) |=> (sel.mode == 2'd0));
endmodule

// File: rtl/tbuf_cmd_decode.sv
module tbuf_cmd_decode
  import tbuf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  parameter int LINE_W  = $clog2(LINES),
  parameter int CHUNK_W = $clog2(CHUNKS)
) (
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  sel_reg_t           sel,
  output logic               commit,
  output logic [LINE_W-1:0]  line,
  output logic [CHUNK_W-1:0] chunk
);
  localparam logic [11:0] LINES_L  = 12'(LINES);
  localparam logic [3:0]  CHUNKS_L = 4'(CHUNKS);

  cmd_reg_t cmd;
  logic     is_cmd, op_ok, mode_ok, range_ok;
  logic     unused_fields;

  always_comb begin
    cmd      = cmd_reg_t'(wr_data);
    is_cmd   = wr_en && (wr_addr == OFS_CMD);
    op_ok    = (cmd.op_b == OP_STORE);
    mode_ok  = (sel.mode == MODE_LOAD) && (sel.array_sel == 5'd0) && !sel.replicate;
    range_ok = (cmd.line_addr < LINES_L) && (sel.chunk_sel < CHUNKS_L);
    commit   = is_cmd && op_ok && mode_ok && range_ok;
    line     = cmd.line_addr[LINE_W-1:0];
    chunk    = sel.chunk_sel[CHUNK_W-1:0];
  end

  assign unused_fields = ^{cmd.op_a, cmd.op_c, cmd.pol0, cmd.pol1, cmd.seq_en,
                           cmd.addr_en, cmd.rsv, sel.rsv31, sel.shadow, sel.stage_en,
                           sel.mpb_ofs, sel.mp_map, sel.dword, sel.compare, sel.rsv4};
endmodule

// File: rtl/tbuf_store.sv
module tbuf_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rsp_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_en;
  end

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
endmodule

// File: rtl/tbuf_load_port.sv
module tbuf_load_port
  import tbuf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [5:0]  rd_line,
  input  logic [2:0]  rd_chunk,
  output logic        rsp_valid,
  output logic [63:0] rsp_data
);
  localparam int LINE_W  = $clog2(LINES);
  localparam int CHUNK_W = $clog2(CHUNKS);
  localparam int IDX_W   = LINE_W + CHUNK_W;
  localparam int DEPTH   = LINES * CHUNKS;
  localparam int DATA_W  = 2 * REG_W;

  logic               cfg_fire, rd_fire, commit;
  logic [DATA_W-1:0]  staged;
  sel_reg_t           sel;
  logic [LINE_W-1:0]  c_line;
  logic [CHUNK_W-1:0] c_chunk;

  assign cfg_ready = 1'b1;
  assign rd_ready  = 1'b1;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign rd_fire   = rd_valid && rd_ready;

  tbuf_stage_regs #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_fire), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .staged(staged), .sel(sel)
  );

  tbuf_cmd_decode #(.LINES(LINES), .CHUNKS(CHUNKS), .LINE_W(LINE_W), .CHUNK_W(CHUNK_W)) u_dec (
    .wr_en(cfg_fire), .wr_addr(cfg_addr), .wr_data(cfg_wdata), .sel(sel),
    .commit(commit), .line(c_line), .chunk(c_chunk)
  );

  tbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx({c_line, c_chunk}),
    .wr_data(staged), .rd_en(rd_fire), .rd_idx({rd_line, rd_chunk}),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  p_commit_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (sel.mode == MODE_LOAD && sel.array_sel == 5'd0 && !sel.replicate));

  p_commit_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cfg_wdata[27:24] == OP_STORE && cfg_addr == OFS_CMD));

  p_commit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cfg_wdata[11:0] < 12'(LINES) && sel.chunk_sel < 4'(CHUNKS)));
endmodule

// File: tb/tbuf_load_port_test.sv
module tbuf_load_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEL_LOAD = 32'h0001_0000;
  localparam logic [31:0] CMD_ST   = 32'h0800_0000;

  logic        clk = 0, rst_n = 0;
  logic        cfg_valid = 0, cfg_ready, rd_valid = 0, rd_ready, rsp_valid;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [5:0]  rd_line = 0;
  logic [2:0]  rd_chunk = 0;
  logic [63:0] rsp_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl [512];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbuf_load_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_line(rd_line), .rd_chunk(rd_chunk), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic stage(input logic [63:0] d);
    cfg_wr(2'd0, d[31:0]);
    cfg_wr(2'd1, d[63:32]);
  endtask

  task automatic store_at(input int line, input int chunk, input logic [63:0] d);
    stage(d);
    cfg_wr(2'd2, SEL_LOAD | 32'(chunk));
    cfg_wr(2'd3, CMD_ST | 32'(line));
    mdl[line*8+chunk] = d;
  endtask

  task automatic rd(input int line, input int chunk, input string tag);
    @(negedge clk);
    rd_valid = 1; rd_line = 6'(line); rd_chunk = 3'(chunk);
    exp_q.push_back(mdl[line*8+chunk]); tag_q.push_back(tag);
    @(negedge clk);
    rd_valid = 0;
  endtask

  // monitor: pops scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected response", rsp_data, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 / R10: reset state
    chk(rsp_valid == 0, "R9 rsp_valid in reset", 64'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(cfg_ready && rd_ready, "R10 ready high", 64'({cfg_ready, rd_ready}), 64'h3);

    // R1, R2: basic stores, boundaries and patterns
    store_at(0, 0, 64'hA5A5_0001_5A5A_0002);
    rd(0, 0, "R1 R2 line0 chunk0");
    store_at(63, 7, 64'hFFFF_0000_1234_8765);
    rd(63, 7, "R2 last line last chunk");
    for (int i = 0; i < 4; i++) begin
      store_at(2 + i * 13, i * 2 + 1, {32'(i) ^ 32'hC0DE_0000, 32'hFACE_0000 + 32'(i)});
    end
    for (int i = 0; i < 4; i++) rd(2 + i * 13, i * 2 + 1, "R2 pattern sweep");

    // R1: staged data reused by a second commit
    store_at(1, 3, 64'h0F0F_1111_2222_F0F0);
    cfg_wr(2'd2, SEL_LOAD | 32'd4);
    cfg_wr(2'd3, CMD_ST | 32'd1);
    mdl[1*8+4] = 64'h0F0F_1111_2222_F0F0;
    rd(1, 4, "R1 staged data persists");

    // R4: other opcodes ignored
    stage(64'hDEAD_BEEF_DEAD_BEEF);
    cfg_wr(2'd2, SEL_LOAD);
    cfg_wr(2'd3, 32'h0700_0000);
    cfg_wr(2'd3, 32'h8080_0000);
    rd(0, 0, "R4 wrong op_b ignored");

    // R3: mode, array and replicate gating
    cfg_wr(2'd2, 32'h0002_0000);
    cfg_wr(2'd3, CMD_ST);
    rd(0, 0, "R3 mode 2 ignored");
    cfg_wr(2'd2, SEL_LOAD | 32'h20);
    cfg_wr(2'd3, CMD_ST);
    rd(0, 0, "R3 array select ignored");
    cfg_wr(2'd2, SEL_LOAD | 32'h800);
    cfg_wr(2'd3, CMD_ST);
    rd(0, 0, "R3 replicate ignored");

    // R5: out-of-range line and chunk do not wrap
    cfg_wr(2'd2, SEL_LOAD);
    cfg_wr(2'd3, CMD_ST | 32'd64);
    rd(0, 0, "R5 line 64 ignored");
    cfg_wr(2'd2, SEL_LOAD | 32'd8);
    cfg_wr(2'd3, CMD_ST);
    rd(0, 0, "R5 chunk 8 ignored");

    // R6: clearing the selection register idles the port
    store_at(10, 0, 64'h1010_0000_0000_0A0A);
    cfg_wr(2'd2, 32'h0);
    stage(64'h9999_9999_9999_9999);
    cfg_wr(2'd3, CMD_ST | 32'd10);
    rd(10, 0, "R6 idle after clear");

    // R8: same-cycle read and commit to one entry
    store_at(20, 5, 64'h0000_1111_0000_1111);
    stage(64'h2222_0000_2222_0000);
    cfg_wr(2'd2, SEL_LOAD | 32'd5);
    @(negedge clk);
    cfg_valid = 1; cfg_addr = 2'd3; cfg_wdata = CMD_ST | 32'd20;
    rd_valid = 1; rd_line = 6'd20; rd_chunk = 3'd5;
    exp_q.push_back(mdl[20*8+5]); tag_q.push_back("R8 same-cycle read gets old");
    @(negedge clk);
    cfg_valid = 0; rd_valid = 0;
    mdl[20*8+5] = 64'h2222_0000_2222_0000;
    rd(20, 5, "R8 following read gets new");

    // R7: back-to-back requests
    @(negedge clk);
    rd_valid = 1; rd_line = 6'd0; rd_chunk = 3'd0;
    exp_q.push_back(mdl[0]); tag_q.push_back("R7 back-to-back first");
    @(negedge clk);
    rd_line = 6'd63; rd_chunk = 3'd7;
    exp_q.push_back(mdl[63*8+7]); tag_q.push_back("R7 back-to-back second");
    @(negedge clk);
    rd_valid = 0;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all responses seen", 64'(exp_q.size()), 0);

    // R9: reset mid-run clears selection, keeps contents
    store_at(5, 2, 64'h5555_AAAA_5555_AAAA);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk(rsp_valid == 0, "R9 rsp_valid low after mid reset", 64'(rsp_valid), 0);
    stage(64'h7777_7777_7777_7777);
    cfg_wr(2'd3, CMD_ST | 32'd5);
    rd(5, 2, "R9 command alone after reset ignored");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", 64'(exp_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule